// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This unit executes the atomic store-class memory operations of a 64-bit register virtual machine against a single-port synchronous memory. One request carries a byte address, already formed from the base register and the sign-extended offset, together with the source register value, the current R0 value, a two-bit access size and the eight-bit operation code taken from the immediate. The unit runs an indivisible sequence: read, modify, write (dropped when a compare fails), respond. It then reports the register write-backs the operation calls for.

A lock output is high from the read cycle through the write cycle. Any other requester of the same memory must stay off the memory while the lock is high. A request is accepted only while the unit is idle. Illegal sizes, unknown operation codes and misaligned addresses produce an error response and no memory access. Memory words are 64 bits wide, with byte enables. A word (32-bit) access uses the half that address bit 2 selects.

Top module: `amo_unit`

## Requirements
- R1: Operation codes 0x00 (add), 0x40 (or), 0x50 (and) and 0xa0 (xor) replace the addressed memory value with the old value combined with src. Setting bit 0 of the code (0x01, 0x41, 0x51, 0xa1) also returns the old memory value on the src write-back. Without bit 0 no write-back occurs.
- R2: Code 0xe1 (exchange) stores src to memory and returns the old memory value on the src write-back.
- R3: Code 0xf1 (compare-exchange) stores src when the old memory value equals R0, and returns the old value on the R0 write-back. It never raises the src write-back.
- R4: When a compare-exchange finds the values unequal, memory is not written. The old value is still returned on the R0 write-back, and the response comes one cycle earlier than for a write.
- R5: Size code 0 selects a 32-bit access and size code 3 a 64-bit access. A 32-bit access computes on the low 32 bits of the operands only. It writes only the half that address bit 2 selects (1 = upper) and leaves the other half unchanged. Its returned values are zero-extended to 64 bits.
- R6: Size codes 1 and 2 produce an error response in the cycle after acceptance. Memory is neither accessed nor locked, and no register write-back is made.
- R7: Any operation code other than the ten listed in R1 to R3, including 0xe0 and 0xf0, produces the same error response as R6.
- R8: A 32-bit access whose address bits [1:0] are not zero, or a 64-bit access whose address bits [2:0] are not zero, produces the same error response as R6.
- R9: The lock is high in exactly the read, modify and write cycles, and the memory is enabled only while the lock is high.
- R10: For an operation that writes, the lock is high in the first three cycles after the accepting edge. The one-cycle done pulse comes in the fourth cycle.
- R11: A request presented while an operation is in progress is ignored, and neither memory nor the responses reflect it.
- R12: After reset the lock, done, error and both write-back strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present; taken only while idle |
| reqAddr | input | ADDR_W | Byte address of the operand |
| reqSrc | input | 64 | Source register value |
| reqR0 | input | 64 | R0 value, the comparand of compare-exchange |
| reqSize | input | 2 | Access size code (0 word, 3 double word) |
| reqOp | input | 8 | Operation code from the immediate |
| lock | output | 1 | Memory reserved for this unit |
| memEn | output | 1 | Memory access enable |
| memWe | output | 1 | Memory write enable |
| memAddr | output | ADDR_W-3 | Memory word index |
| memBe | output | 8 | Byte enables for the write |
| memWdata | output | 64 | Write data |
| memRdata | input | 64 | Read data, valid one cycle after a read |
| doneValid | output | 1 | One-cycle response pulse |
| errFlag | output | 1 | Response is an error (with doneValid) |
| srcWe | output | 1 | Write old value to the source register |
| srcData | output | 64 | Value for the source register |
| r0We | output | 1 | Write old value to R0 |
| r0Data | output | 64 | Value for R0 |

## Verification
The bench targets the half-word placement of 32-bit accesses. A design that ignored address bit 2 or the byte enables would corrupt the neighbouring half, and 32-bit add carries that wrap at the half boundary expose this. It drives compare-exchange with both a matching and a mismatching R0. A design that wrote on a mismatch, wrote src instead of R0, or kept the full-length timing shows up in memory and in the done cycle. It sends the codes next to the legal ones (0xe0, 0xf0, 0x42), the two illegal sizes and misaligned addresses; a design that let any of these reach memory changes the memory image. It also holds a second request valid through a running operation, which a design that re-accepted it would turn into an extra write.

// File: rtl/amo_pkg.sv
package amo_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_MODIFY, ST_WRITE, ST_RESPOND
  } amoState_e;

  typedef enum logic [2:0] {
    OP_ADD, OP_OR, OP_AND, OP_XOR, OP_XCHG, OP_CMPX
  } amoOp_e;

  typedef struct packed {
    logic capReq;
    logic capOld;
    logic respond;
  } amoStrobe_t;

  localparam logic [1:0] SZ_WORD  = 2'd0;
  localparam logic [1:0] SZ_DWORD = 2'd3;

  localparam logic [7:0] IMM_ADD  = 8'h00;
  localparam logic [7:0] IMM_OR   = 8'h40;
  localparam logic [7:0] IMM_AND  = 8'h50;
  localparam logic [7:0] IMM_XOR  = 8'ha0;
  localparam logic [7:0] IMM_XCHG = 8'he1;
  localparam logic [7:0] IMM_CMPX = 8'hf1;
endpackage

// File: rtl/amo_ctrl.sv
module amo_ctrl
  import amo_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqLegal,
  input  logic       isCmp,
  input  logic       cmpHit,
  output amoStrobe_t strobe,
  output logic       lock,
  output logic       memEn,
  output logic       memWe,
  output logic       doneValid
);
  amoState_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:    if (reqValid) stateNext = reqLegal ? ST_READ : ST_RESPOND;
      ST_READ:    stateNext = ST_MODIFY;
      ST_MODIFY:  stateNext = (isCmp && !cmpHit) ? ST_RESPOND : ST_WRITE;
      ST_WRITE:   stateNext = ST_RESPOND;
      ST_RESPOND: stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.capReq  = (state == ST_IDLE) && reqValid;
    strobe.capOld  = (state == ST_MODIFY);
    strobe.respond = (state == ST_RESPOND);
  end

  assign lock      = (state == ST_READ) || (state == ST_MODIFY) || (state == ST_WRITE);
  assign memEn     = (state == ST_READ) || (state == ST_WRITE);
  assign memWe     = (state == ST_WRITE);
  assign doneValid = (state == ST_RESPOND);

  AST_MEM_UNDER_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    memEn |-> lock); // R9
  AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> $past(lock)); // R9
  AST_CMP_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capOld && isCmp && !cmpHit) |=> !memWe); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid); // R10
endmodule

// File: rtl/amo_datapath.sv
module amo_datapath
  import amo_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  amoStrobe_t               strobe,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqSrc,
  input  logic [DATA_W-1:0]        reqR0,
  input  logic [1:0]               reqSize,
  input  logic [7:0]               reqOp,
  input  logic [DATA_W-1:0]        memRdata,
  output logic                     reqLegal,
  output logic                     isCmp,
  output logic                     cmpHit,
  output logic [ADDR_W-OFF_W-1:0]  memAddr,
  output logic [BYTES-1:0]         memBe,
  output logic [DATA_W-1:0]        memWdata,
  output logic                     srcWe,
  output logic [DATA_W-1:0]        srcData,
  output logic                     r0We,
  output logic [DATA_W-1:0]        r0Data,
  output logic                     errFlag
);
  localparam int BYTES  = DATA_W / 8;
  localparam int OFF_W  = $clog2(BYTES);
  localparam int HALF_W = DATA_W / 2;
  localparam int HALF_B = BYTES / 2;

  // request decode
  amoOp_e opKind;
  logic   opLegal, sizeLegal, aligned, wordReq;

  always_comb begin
    opLegal = 1'b1;
    opKind  = OP_ADD;
    unique case (reqOp)
      IMM_ADD, IMM_ADD | 8'h01: opKind = OP_ADD;
      IMM_OR,  IMM_OR  | 8'h01: opKind = OP_OR;
      IMM_AND, IMM_AND | 8'h01: opKind = OP_AND;
      IMM_XOR, IMM_XOR | 8'h01: opKind = OP_XOR;
      IMM_XCHG:                 opKind = OP_XCHG;
      IMM_CMPX:                 opKind = OP_CMPX;
      default:                  opLegal = 1'b0;
    endcase
  end

  assign wordReq   = (reqSize == SZ_WORD);
  assign sizeLegal = wordReq || (reqSize == SZ_DWORD);
  assign aligned   = wordReq ? (reqAddr[1:0] == 2'b00) : (reqAddr[OFF_W-1:0] == '0);
  assign reqLegal  = opLegal && sizeLegal && aligned;

  // captured request
  logic [ADDR_W-OFF_W-1:0] wordAddrQ;
  logic                    hiHalfQ, wordQ, fetchQ, errQ;
  amoOp_e                  opQ;
  logic [DATA_W-1:0]       srcQ, r0Q, oldQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordAddrQ <= '0;
      hiHalfQ   <= 1'b0;
      wordQ     <= 1'b0;
      fetchQ    <= 1'b0;
      errQ      <= 1'b0;
      opQ       <= OP_ADD;
      srcQ      <= '0;
      r0Q       <= '0;
    end else if (strobe.capReq) begin
      wordAddrQ <= reqAddr[ADDR_W-1:OFF_W];
      hiHalfQ   <= reqAddr[OFF_W-1];
      wordQ     <= wordReq;
      fetchQ    <= reqOp[0];
      errQ      <= !reqLegal;
      opQ       <= opKind;
      srcQ      <= reqSrc;
      r0Q       <= reqR0;
    end
  end

  // read data aligned and zero-extended for word accesses
  logic [DATA_W-1:0] rdSel, srcOp, r0Op;
  assign rdSel = !wordQ  ? memRdata :
                 hiHalfQ ? {{HALF_W{1'b0}}, memRdata[DATA_W-1:HALF_W]}
                         : {{HALF_W{1'b0}}, memRdata[HALF_W-1:0]};
  assign srcOp = wordQ ? {{HALF_W{1'b0}}, srcQ[HALF_W-1:0]} : srcQ;
  assign r0Op  = wordQ ? {{HALF_W{1'b0}}, r0Q[HALF_W-1:0]}  : r0Q;

  assign isCmp  = (opQ == OP_CMPX);
  assign cmpHit = (rdSel == r0Op);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              oldQ <= '0;
    else if (strobe.capOld) oldQ <= rdSel;
  end

  // modify
  logic [DATA_W-1:0] newVal;
  always_comb begin
    unique case (opQ)
      OP_ADD:  newVal = oldQ + srcOp;
      OP_OR:   newVal = oldQ | srcOp;
      OP_AND:  newVal = oldQ & srcOp;
      OP_XOR:  newVal = oldQ ^ srcOp;
      default: newVal = srcOp;
    endcase
  end

  assign memAddr  = wordAddrQ;
  assign memBe    = !wordQ  ? {BYTES{1'b1}} :
                    hiHalfQ ? {{HALF_B{1'b1}}, {HALF_B{1'b0}}}
                            : {{HALF_B{1'b0}}, {HALF_B{1'b1}}};
  assign memWdata = !wordQ  ? newVal :
                    hiHalfQ ? {newVal[HALF_W-1:0], {HALF_W{1'b0}}}
                            : {{HALF_W{1'b0}}, newVal[HALF_W-1:0]};

  // responses
  assign errFlag = strobe.respond && errQ;
  assign srcWe   = strobe.respond && !errQ && !isCmp && (fetchQ || (opQ == OP_XCHG));
  assign r0We    = strobe.respond && !errQ && isCmp;
  assign srcData = oldQ;
  assign r0Data  = oldQ;

  AST_ONE_WRITEBACK: assert property (@(posedge clk) disable iff (!rstN)
    !(srcWe && r0We)); // R3
  AST_ERR_NO_WRITEBACK: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (!srcWe && !r0We)); // R6
  AST_WORD_ZERO_EXT: assert property (@(posedge clk) disable iff (!rstN)
    ((srcWe || r0We) && wordQ) |-> (oldQ[DATA_W-1:HALF_W] == '0)); // R5
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [63:0]       reqSrc,
  input  logic [63:0]       reqR0,
  input  logic [1:0]        reqSize,
  input  logic [7:0]        reqOp,
  output logic              lock,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-4:0] memAddr,
  output logic [7:0]        memBe,
  output logic [63:0]       memWdata,
  input  logic [63:0]       memRdata,
  output logic              doneValid,
  output logic              errFlag,
  output logic              srcWe,
  output logic [63:0]       srcData,
  output logic              r0We,
  output logic [63:0]       r0Data
);
  amoStrobe_t strobe;
  logic reqLegal, isCmp, cmpHit;

  amo_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLegal(reqLegal),
    .isCmp(isCmp), .cmpHit(cmpHit), .strobe(strobe), .lock(lock),
    .memEn(memEn), .memWe(memWe), .doneValid(doneValid)
  );

  amo_datapath #(.ADDR_W(ADDR_W), .DATA_W(64)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqSrc(reqSrc), .reqR0(reqR0), .reqSize(reqSize), .reqOp(reqOp),
    .memRdata(memRdata), .reqLegal(reqLegal), .isCmp(isCmp), .cmpHit(cmpHit),
    .memAddr(memAddr), .memBe(memBe), .memWdata(memWdata), .srcWe(srcWe),
    .srcData(srcData), .r0We(r0We), .r0Data(r0Data), .errFlag(errFlag)
  );
endmodule

// File: tb/amo_unit_tb_top.sv
module amo_unit_tb_top;
  localparam int ADDR_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [63:0] reqSrc = '0, reqR0 = '0;
  logic [1:0] reqSize = '0;
  logic [7:0] reqOp = '0;
  logic lock, memEn, memWe, doneValid, errFlag, srcWe, r0We;
  logic [ADDR_W-4:0] memAddr;
  logic [7:0] memBe;
  logic [63:0] memWdata, memRdata, srcData, r0Data;

  always #5 clk = ~clk;

  amo_unit #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSrc(reqSrc), .reqR0(reqR0), .reqSize(reqSize), .reqOp(reqOp),
    .lock(lock), .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memBe(memBe), .memWdata(memWdata), .memRdata(memRdata),
    .doneValid(doneValid), .errFlag(errFlag), .srcWe(srcWe),
    .srcData(srcData), .r0We(r0We), .r0Data(r0Data)
  );

  // behavioural memory and reference image
  logic [63:0] mem [16];
  logic [63:0] refMem [16];

  always_ff @(posedge clk) begin
    if (memEn) begin
      if (memWe) begin
        for (int b = 0; b < 8; b++)
          if (memBe[b]) mem[memAddr[3:0]][b*8 +: 8] <= memWdata[b*8 +: 8];
      end else begin
        memRdata <= mem[memAddr[3:0]];
      end
    end
  end

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Runs one request through the reference model and compares every cycle.
  task automatic runOp(input logic [15:0] a, input logic [63:0] s, input logic [63:0] r,
                       input logic [1:0] sz, input logic [7:0] op, input string req,
                       input bit junk);
    bit err, isW, fetch, cmp, hit, isX;
    logic [63:0] old, oldSel, sOp, nw;
    int lat;
    int idx;
    isW = (sz == 2'd0);
    err = !(sz == 2'd0 || sz == 2'd3);
    fetch = op[0];
    cmp = 0; isX = 0;
    case (op)
      8'h00, 8'h01, 8'h40, 8'h41, 8'h50, 8'h51, 8'ha0, 8'ha1: ;
      8'he1: isX = 1;
      8'hf1: cmp = 1;
      default: err = 1;
    endcase
    if (isW && a[1:0] != 0) err = 1;
    if (!isW && a[2:0] != 0) err = 1;
    idx = int'(a[6:3]);
    old = refMem[idx];
    oldSel = !isW ? old : (a[2] ? {32'h0, old[63:32]} : {32'h0, old[31:0]});
    sOp = isW ? {32'h0, s[31:0]} : s;
    case (op & 8'hfe)
      8'h00: nw = oldSel + sOp;
      8'h40: nw = oldSel | sOp;
      8'h50: nw = oldSel & sOp;
      8'ha0: nw = oldSel ^ sOp;
      default: nw = sOp;
    endcase
    hit = isW ? (oldSel[31:0] == r[31:0]) : (oldSel == r);
    if (!err && !(cmp && !hit)) begin
      if (!isW) refMem[idx] = nw;
      else if (a[2]) refMem[idx][63:32] = nw[31:0];
      else refMem[idx][31:0] = nw[31:0];
    end
    lat = err ? 1 : (cmp && !hit) ? 3 : 4;

    @(negedge clk);
    reqValid = 1; reqAddr = a; reqSrc = s; reqR0 = r; reqSize = sz; reqOp = op;
    for (int k = 1; k <= lat; k++) begin
      @(negedge clk);
      if (junk && k < lat) begin
        reqAddr = 16'h0040; reqSrc = 64'hdead_beef_0bad_f00d; reqSize = 2'd3; reqOp = 8'hf1;
        reqR0 = refMem[8];
      end else begin
        reqValid = 0;
      end
      chk(lock == (k < lat), {req, " lock"}, {63'h0, lock}, {63'h0, k < lat});
      chk(doneValid == (k == lat), {req, " done"}, {63'h0, doneValid}, {63'h0, k == lat});
    end
    chk(errFlag == err, {req, " err"}, {63'h0, errFlag}, {63'h0, err});
    chk(srcWe == (!err && !cmp && (fetch || isX)), {req, " srcWe"}, {63'h0, srcWe},
        {63'h0, !err && !cmp && (fetch || isX)});
    if (!err && !cmp && (fetch || isX)) chk(srcData == oldSel, {req, " srcData"}, srcData, oldSel);
    chk(r0We == (!err && cmp), {req, " r0We"}, {63'h0, r0We}, {63'h0, !err && cmp});
    if (!err && cmp) chk(r0Data == oldSel, {req, " r0Data"}, r0Data, oldSel);
    for (int i = 0; i < 16; i++)
      if (mem[i] !== refMem[i]) chk(0, {req, " memory"}, mem[i], refMem[i]);
    total++;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i] = 64'h0123_4567_89ab_cdef ^ (64'(i) * 64'h1111_0000_2222_0101);
      refMem[i] = mem[i];
    end
    mem[3] = 64'h1234_5678_ffff_ffff; refMem[3] = mem[3];
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!lock && !doneValid && !errFlag && !srcWe && !r0We, "R12 reset",
        {59'h0, lock, doneValid, errFlag, srcWe, r0We}, 64'h0);
    rstN = 1;
    @(negedge clk);
    chk(!lock && !doneValid, "R12 after release", {62'h0, lock, doneValid}, 64'h0);

    runOp(16'h0008, 64'h0000_0001_0000_0005, 0, 2'd3, 8'h00, "R1 R10 add dword", 0);
    runOp(16'h0008, 64'h10, 0, 2'd3, 8'h01, "R1 add fetch", 0);
    runOp(16'h0014, 64'hffff_ffff_00f0_0f00, 0, 2'd0, 8'h41, "R1 R5 or fetch upper half", 0);
    runOp(16'h0010, 64'h1234_5678_0ff0_ff0f, 0, 2'd0, 8'h50, "R1 R5 and lower half", 0);
    runOp(16'h0020, 64'haaaa_5555_aaaa_5555, 0, 2'd3, 8'ha1, "R1 xor fetch", 0);
    runOp(16'h0018, 64'h1, 0, 2'd0, 8'h01, "R5 word add wraps", 0);
    runOp(16'h0028, 64'hcafe_babe_1234_5678, 0, 2'd3, 8'he1, "R2 xchg dword", 0);
    runOp(16'h002c, 64'hffff_ffff_8765_4321, 0, 2'd0, 8'he1, "R2 R5 xchg word", 0);
    runOp(16'h0030, 64'h7777, refMem[6], 2'd3, 8'hf1, "R3 cmpxchg hit", 0);
    runOp(16'h0034, 64'h5, {32'hffff_ffff, refMem[6][63:32]}, 2'd0, 8'hf1, "R3 R5 cmpxchg word hit", 0);
    runOp(16'h0038, 64'h9, refMem[7] ^ 64'h1, 2'd3, 8'hf1, "R4 cmpxchg miss", 0);
    runOp(16'h003c, 64'h9, 64'h0, 2'd0, 8'hf1, "R4 cmpxchg word miss", 0);
    runOp(16'h0008, 64'h1, 0, 2'd1, 8'h00, "R6 size 1", 0);
    runOp(16'h0008, 64'h1, 0, 2'd2, 8'h01, "R6 size 2", 0);
    runOp(16'h0008, 64'h1, 0, 2'd3, 8'he0, "R7 code e0", 0);
    runOp(16'h0008, 64'h1, refMem[1], 2'd3, 8'hf0, "R7 code f0", 0);
    runOp(16'h0008, 64'h1, 0, 2'd3, 8'h42, "R7 code 42", 0);
    runOp(16'h0012, 64'h1, 0, 2'd0, 8'h00, "R8 word misaligned", 0);
    runOp(16'h000c, 64'h1, 0, 2'd3, 8'h00, "R8 dword misaligned", 0);
    runOp(16'h0048, 64'h3, 0, 2'd3, 8'h01, "R11 request held while busy", 1);
    runOp(16'h004a, 64'h3, 0, 2'd1, 8'h01, "R11 held during error", 1);
    runOp(16'h0050, 64'h1, 0, 2'd3, 8'h51, "R9 R10 back to back", 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule